// File: doc/BRIEF.md
# Compare Match Interval Timer

This block is a single-channel periodic timer. A 16-bit up-counter steps on one of four divided versions of the peripheral clock and is compared against a 16-bit limit held in a register. When a counting step finds the counter equal to the limit, the counter returns to zero and a sticky match flag is raised. If the interrupt enable is on, the flag drives an interrupt request.

Software uses a small register port to reach four registers: a run control, a control/status word, the counter and the limit. The match flag cannot simply be written away. It is cleared by a read that returns it as 1, followed by a write of 0. If another match lands between the read and the write, the write leaves the flag set, so no event is lost. A transfer engine serving the interrupt can also clear the flag through a one-cycle acknowledge input.

Top module: `match_timer`

## Requirements
- R1: After reset, the run register (offset 0) reads 0x0000, the control/status word (offset 1) reads 0x0000, the counter (offset 2) reads 0x0000, the limit (offset 3) reads 0xFFFF, and `irq` is low.
- R2: The 2-bit select field in bits 1:0 of the control/status word picks a step ratio: 0 gives 8 clocks, 1 gives 32, 2 gives 128 and 3 gives 512. Counting starts from a counter of 0 with the divider at zero on the clock edge that writes run = 1. The first match then falls exactly ratio × (limit + 1) clock edges later.
- R3: The counter steps only while bit 0 of the run register is 1. Writing 0 to that bit freezes the counter at its current value.
- R4: Each step adds 1 to the counter. The step that finds the counter equal to the limit sets the match flag and returns the counter to 0.
- R5: In the control/status word, bit 7 is the match flag, bit 6 the interrupt enable and bits 1:0 the select. All other bits read 0 and ignore writes. Writing 1 to bit 7 never sets the flag.
- R6: A write of 0 to bit 7 clears the flag only if a read of the control/status word returned the flag as 1 since the last match. Without such a read, the write leaves the flag at 1.
- R7: If a match happens after the arming read and before the write of 0, the write leaves the flag at 1. A fresh read followed by a write of 0 then clears it.
- R8: A read of the control/status word in the same cycle as a match does not arm the clear.
- R9: A match in the same cycle as an armed clearing write leaves the flag set.
- R10: `irq` is high exactly while the match flag and the interrupt enable are both 1.
- R11: A one-cycle pulse on `xfer_ack` clears the match flag without any prior read.
- R12: The counter and the limit are writable at offsets 2 and 3 and read back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read while `bus_sel` is high |
| bus_addr | input | 2 | Register offset: 0 run, 1 control/status, 2 counter, 3 limit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| xfer_ack | input | 1 | Transfer-engine acknowledge that clears the match flag |
| irq | output | 1 | Compare match interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a divider with a base of 3 and a step of 2 bits. Because even the slowest ratio (512 clocks) is short, every select value can be timed to the exact edge within a small cycle budget. Small limit values keep the match schedule known to the edge. That lets the bench place reads and writes exactly on, before or after a match and reach the clear races directly.

// File: rtl/match_timer_pkg.sv
// Shared register offsets and control/status bit positions for the
// compare match interval timer. Assumes a 2-bit register offset.
package match_timer_pkg;

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned SEL_W  = 2;

    // Register offsets on the access port
    typedef enum logic [ADDR_W-1:0] {
        REG_RUN = 2'd0,
        REG_CSR = 2'd1,
        REG_CNT = 2'd2,
        REG_LIM = 2'd3
    } reg_off_e;

    // Bit positions inside the control/status word
    localparam int unsigned CSR_FLAG_BIT = 7;
    localparam int unsigned CSR_IE_BIT   = 6;
    localparam int unsigned CSR_SEL_LSB  = 0;

endpackage

// File: rtl/mt_prescaler.sv
// Free-running clock divider that issues a one-cycle step pulse at one of
// 2**SEL_W ratios. Ratio g is 2**(BASE_LOG + STEP_LOG*g). The divider is
// held at zero while run is low, so the first step after starting comes
// a full ratio later. Assumes sel is stable while running.
module mt_prescaler #(
    parameter int unsigned BASE_LOG = 3,
    parameter int unsigned STEP_LOG = 2,
    parameter int unsigned SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned N_SEL = 1 << SEL_W;
    localparam int unsigned PRE_W = BASE_LOG + STEP_LOG * (N_SEL - 1);

    logic [PRE_W-1:0] pre_q;
    logic [N_SEL-1:0] hit;

    // Divider count: advances while running, cleared when stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One terminal-count detector per ratio: low bits all ones
    for (genvar g = 0; g < N_SEL; g++) begin : g_ratio
        localparam int unsigned W = BASE_LOG + STEP_LOG * g;
        assign hit[g] = &pre_q[W-1:0];
    end

    assign tick = run & hit[sel];

endmodule

// File: rtl/mt_counter.sv
// Up-counter and limit register. On a step, a counter equal to the limit
// produces a match and returns to zero; otherwise it adds one. A software
// write to the counter takes priority over a step in the same cycle.
module mt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_lim,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] lim,
    output logic             match
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;

    assign match = tick && (cnt_q == lim_q);

    // Counter: software load, else step with wrap at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= match ? '0 : cnt_q + 1'b1;
        end
    end

    // Limit register: resets to all ones, loaded by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '1;
        end else if (wr_lim) begin
            lim_q <= wdata;
        end
    end

    assign cnt = cnt_q;
    assign lim = lim_q;

endmodule

// File: rtl/mt_flag.sv
// Sticky match flag with a guarded clear. A read that sees the flag at 1
// with no match in the same cycle arms the clear. A later write of 0
// clears the flag only while armed. Any match disarms and wins over a
// clear. The acknowledge input clears the flag directly.
module mt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic rd_csr,
    input  logic wr_csr,
    input  logic wflag,
    input  logic ack,
    output logic flag,
    output logic armed
);
    logic flag_q;
    logic armed_q;
    logic clr_write;

    assign clr_write = wr_csr && !wflag;

    // Flag: a set beats every clearing source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if ((clr_write && armed_q) || ack) begin
            flag_q <= 1'b0;
        end
    end

    // Arm bit: remembers a read of 1 until a match or a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (match || clr_write || ack) begin
            armed_q <= 1'b0;
        end else if (rd_csr && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag  = flag_q;
    assign armed = armed_q;

endmodule

// File: rtl/match_timer.sv
// Compare match interval timer top. Decodes the register port, holds the
// run bit, interrupt enable and ratio select, and ties together the
// divider, the counter and the guarded flag. Assumes one access per
// cycle; read data is combinational on the offset.
module match_timer
    import match_timer_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned BASE_LOG = 3,
    parameter int unsigned STEP_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              xfer_ack,
    output logic              irq
);
    reg_off_e         off;
    logic             wr_run, wr_csr, wr_cnt, wr_lim, rd_csr;
    logic             run_q, ie_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick, match, flag, armed;
    logic [CNT_W-1:0] cnt, lim;

    assign off    = reg_off_e'(bus_addr);
    assign wr_run = bus_sel &&  bus_wr && (off == REG_RUN);
    assign wr_csr = bus_sel &&  bus_wr && (off == REG_CSR);
    assign wr_cnt = bus_sel &&  bus_wr && (off == REG_CNT);
    assign wr_lim = bus_sel &&  bus_wr && (off == REG_LIM);
    assign rd_csr = bus_sel && !bus_wr && (off == REG_CSR);

    // Control bits: run, interrupt enable and ratio select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            if (wr_run) run_q <= bus_wdata[0];
            if (wr_csr) begin
                ie_q  <= bus_wdata[CSR_IE_BIT];
                sel_q <= bus_wdata[CSR_SEL_LSB +: SEL_W];
            end
        end
    end

    mt_prescaler #(
        .BASE_LOG (BASE_LOG),
        .STEP_LOG (STEP_LOG),
        .SEL_W    (SEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .sel   (sel_q),
        .tick  (tick)
    );

    mt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr_cnt (wr_cnt),
        .wr_lim (wr_lim),
        .wdata  (bus_wdata),
        .cnt    (cnt),
        .lim    (lim),
        .match  (match)
    );

    mt_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .match  (match),
        .rd_csr (rd_csr),
        .wr_csr (wr_csr),
        .wflag  (bus_wdata[CSR_FLAG_BIT]),
        .ack    (xfer_ack),
        .flag   (flag),
        .armed  (armed)
    );

    // Read mux: reserved bits are constant zero
    always_comb begin
        bus_rdata = '0;
        unique case (off)
            REG_RUN: bus_rdata[0] = run_q;
            REG_CSR: begin
                bus_rdata[CSR_FLAG_BIT]             = flag;
                bus_rdata[CSR_IE_BIT]               = ie_q;
                bus_rdata[CSR_SEL_LSB +: SEL_W]     = sel_q;
            end
            REG_CNT: bus_rdata = cnt;
            REG_LIM: bus_rdata = lim;
        endcase
    end

    assign irq = flag & ie_q;

endmodule

// File: rtl/match_timer_chk.sv
// Property checker for the interval timer, attached by bind below.
module match_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             match,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim,
    input logic             wr_cnt,
    input logic             run,
    input logic             flag,
    input logic             armed,
    input logic             ie,
    input logic             ack,
    input logic             rd_csr,
    input logic [CNT_W-1:0] rdata,
    input logic             irq
);
    // R4: a step at the limit returns the counter to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == lim) && !wr_cnt) |=> (cnt == '0));

    // R9: a match always leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    // R6: an unarmed flag survives without acknowledge
    a_r6_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed && !ack) |=> flag);

    // R3: a stopped counter holds unless written
    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt));

    // R10: the request needs both flag and enable
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ie));

    // R11: acknowledge clears the flag when no match competes
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !match) |=> !flag);

    // R5: reserved bits of the control/status word read zero
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_csr |-> ((rdata[15:8] == 8'h00) && (rdata[5:2] == 4'h0)));

    // R8: a match leaves the clear disarmed
    a_r8_match_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !armed);

endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .match  (match),
    .cnt    (cnt),
    .lim    (lim),
    .wr_cnt (wr_cnt),
    .run    (run_q),
    .flag   (flag),
    .armed  (armed),
    .ie     (ie_q),
    .ack    (xfer_ack),
    .rd_csr (rd_csr),
    .rdata  (bus_rdata),
    .irq    (irq)
);

// File: tb/test_match_timer.sv
module test_match_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        xfer_ack = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int ecount = 0;
    logic [15:0] rd;

    always #2.5 clk = ~clk;

    match_timer i_match_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .xfer_ack  (xfer_ack),
        .irq       (irq)
    );

    // {select, limit, expected edges to first match}: ratio * (limit + 1)
    localparam logic [49:0] VEC [6] = '{
        {2'd0, 16'd0, 32'd8},
        {2'd0, 16'd5, 32'd48},
        {2'd1, 16'd2, 32'd96},
        {2'd2, 16'd1, 32'd256},
        {2'd3, 16'd0, 32'd512},
        {2'd1, 16'd7, 32'd256}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; xfer_ack = 1'b0;
        @(posedge clk);
        ecount++;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; xfer_ack = 1'b0;
        @(posedge clk);
        ecount++;
    endtask

    task automatic rdr(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; xfer_ack = 1'b0;
        #1 d = bus_rdata;
        @(posedge clk);
        ecount++;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; xfer_ack = 1'b1;
        @(posedge clk);
        ecount++;
    endtask

    task automatic idle_until(input int k);
        while (ecount < k) idle();
    endtask

    task automatic start();
        wr(2'd0, 16'h0001);
        ecount = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        #1 check("R1 irq", {31'd0, irq}, 32'd0);
        rdr(2'd0, rd); check("R1 run", {16'd0, rd}, 32'h0000);
        rdr(2'd1, rd); check("R1 csr", {16'd0, rd}, 32'h0000);
        rdr(2'd2, rd); check("R1 counter", {16'd0, rd}, 32'h0000);
        rdr(2'd3, rd); check("R1 limit", {16'd0, rd}, 32'hFFFF);

        // R2: table walk, time to first match per select and limit
        for (int i = 0; i < 6; i++) begin
            int n;
            logic [1:0]  s;
            logic [15:0] c;
            logic [31:0] e;
            {s, c, e} = VEC[i];
            wr(2'd0, 16'h0000);
            wr(2'd2, 16'h0000);
            wr(2'd3, c);
            wr(2'd1, 16'h0040 | {14'd0, s});
            rdr(2'd1, rd);
            wr(2'd1, 16'h0040 | {14'd0, s});
            start();
            n = 0;
            while (n < 20000) begin
                idle();
                n++;
                #1;
                if (irq) break;
            end
            check($sformatf("R2 period vec%0d", i), n, e);
            wr(2'd0, 16'h0000);
        end

        // R10: flag 1 with enable 1 drives the request
        #1 check("R10 irq on", {31'd0, irq}, 32'd1);
        // R6: write 0 without a read leaves the flag; also disables irq
        wr(2'd1, 16'h0000);
        #1 check("R10 irq masked", {31'd0, irq}, 32'd0);
        rdr(2'd1, rd); check("R6 unarmed write", {16'd0, rd}, 32'h0080);
        wr(2'd1, 16'h0040);
        rdr(2'd1, rd); check("R6 armed clear", {16'd0, rd}, 32'h0040);
        #1 check("R10 irq flag low", {31'd0, irq}, 32'd0);

        // R5: reserved bits and a 1 written to the flag
        wr(2'd1, 16'hFFFF);
        rdr(2'd1, rd); check("R5 reserved", {16'd0, rd}, 32'h0043);
        wr(2'd1, 16'h0000);

        // R12: counter and limit read back
        wr(2'd2, 16'h1234);
        rdr(2'd2, rd); check("R12 counter", {16'd0, rd}, 32'h1234);
        wr(2'd3, 16'h00AB);
        rdr(2'd3, rd); check("R12 limit", {16'd0, rd}, 32'h00AB);

        // R3: a stopped counter holds
        repeat (50) idle();
        rdr(2'd2, rd); check("R3 hold", {16'd0, rd}, 32'h1234);

        // R4: limit 3, ratio 8: steps at edges 8,16,24,32
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0003);
        start();
        idle_until(20);
        rdr(2'd2, rd); check("R4 count", {16'd0, rd}, 32'h0002);
        idle_until(33);
        rdr(2'd2, rd); check("R4 wrap", {16'd0, rd}, 32'h0000);
        rdr(2'd1, rd); check("R4 flag", {16'd0, rd}, 32'h0080);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0000);

        // R7: limit 0, matches at every 8th edge; match between read and write
        start();
        idle_until(9);
        rdr(2'd1, rd);
        idle_until(20);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
        rdr(2'd1, rd); check("R7 write after new match", {16'd0, rd}, 32'h0080);
        wr(2'd1, 16'h0000);
        rdr(2'd1, rd); check("R7 re-read clears", {16'd0, rd}, 32'h0000);

        // R8: read on a match edge does not arm
        start();
        idle_until(15);
        rdr(2'd1, rd);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
        rdr(2'd1, rd); check("R8 read at match", {16'd0, rd}, 32'h0080);

        // R11: acknowledge clears
        ack_pulse();
        rdr(2'd1, rd); check("R11 ack clear", {16'd0, rd}, 32'h0000);

        // R9: armed write on a match edge
        start();
        idle_until(9);
        rdr(2'd1, rd);
        idle_until(15);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
        rdr(2'd1, rd); check("R9 set wins", {16'd0, rd}, 32'h0080);

        summary();
        $finish;
    end

endmodule